// File: doc/BRIEF.md
# Predicated Vector Register Writeback

This block is the last stage of a vector datapath. It holds a file of four-lane registers and a four-bit predicate register. On every valid instruction it decides which lanes of the destination register take the incoming result. The decision combines the instruction's destination write mask with the predicate register. Before the AND, the predicate can be swizzled (identity or a broadcast of one lane) and can be inverted. Lanes that are not enabled keep their old contents.

The predicate register is changed only by a dedicated set-predicate instruction. That instruction compares two four-lane operands lane by lane with a selectable signed test, and it updates only the predicate bits its own write mask selects.

Some requests are not allowed: an unsupported swizzle, predication asked of an instruction class that cannot be predicated, a reserved class, or an unknown compare code. Each of these raises a registered error flag and discards the instruction. A synchronous read port with one cycle of latency returns whole registers. Lane 0 (x) sits in bits [31:0] of a vector, and lane 3 (w) in bits [127:96].

Top module: `vpred_writeback`

## Requirements
- R1: For a valid class-0 (ALU) instruction, lane i of register `dst_i` is written when `wmask_i[i]` is set. If `pen_i`=1, the selected predicate bit for lane i must also be 1. If `pen_i`=0, the predicate plays no part.
- R2: When `pinv_i`=1, each swizzled predicate bit is inverted before the AND with the write mask.
- R3: Swizzle code 0 gives lane i predicate bit i. Codes 1, 2, 3 and 4 broadcast predicate bit 0, 1, 2 and 3 to every lane.
- R4: With `pen_i`=1, swizzle codes 5 to 7 set `err_o` on the next cycle and write no lane. With `pen_i`=0, the swizzle code is ignored.
- R5: With `pen_i`=1, class 1 (flow) and class 2 (set-predicate) instructions set `err_o` on the next cycle and change neither the registers nor the predicate. Class 3 always sets `err_o` and has no effect.
- R6: A lane that is not enabled keeps its previous value. Class 1 instructions write no register.
- R7: ALU writes, predicated or not, never change `pred_o`.
- R8: A class 2 instruction compares lane i of `res_i` (A) against lane i of `opb_i` (B) as signed integers. Compare codes are 0 GT, 1 LT, 2 GE, 3 LE, 4 EQ and 5 NE. Each result is stored in predicate bit i only where `wmask_i[i]` is set; the other bits are kept.
- R9: Compare codes 6 and 7 set `err_o` on the next cycle and leave the predicate unchanged.
- R10: `rd_data_o` shows the register addressed by `rd_idx_i` one cycle later. A write is visible to reads issued from the next cycle on. A read in the same cycle as a write to the same register returns the old data.
- R11: After reset, `pred_o`, `err_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Instruction valid |
| cls_i | input | 2 | Instruction class: 0 ALU, 1 flow, 2 set-predicate, 3 reserved |
| dst_i | input | 4 | Destination register index |
| wmask_i | input | 4 | Destination lane write mask (bit i = lane i) |
| pen_i | input | 1 | Predication requested |
| pinv_i | input | 1 | Invert the predicate |
| pswz_i | input | 3 | Predicate swizzle code |
| cmp_i | input | 3 | Compare code for set-predicate |
| res_i | input | 128 | Result vector, or operand A for set-predicate |
| opb_i | input | 128 | Operand B for set-predicate |
| rd_idx_i | input | 4 | Read register index |
| rd_data_o | output | 128 | Registered read data |
| pred_o | output | 4 | Predicate register |
| err_o | output | 1 | Registered error flag for the previous instruction |

## Verification
The bench builds the block with its defaults: 32-bit lanes and 16 registers. With 32-bit lanes it can pair an all-ones operand against a small positive one, so the tests show whether the comparator treats lanes as signed or unsigned. With 16 registers the top index, 15, can be reached along with a middle one. Every swizzle and inversion is tested against a predicate that is neither all ones nor all zeros. Because of that, a wrong lane selection changes which lanes are written.

// File: rtl/vpred_pkg.sv
`timescale 1ns/1ps
package vpred_pkg;
  localparam int LANES = 4;

  localparam logic [1:0] CLS_ALU  = 2'd0;
  localparam logic [1:0] CLS_FLOW = 2'd1;
  localparam logic [1:0] CLS_SETP = 2'd2;
  localparam logic [1:0] CLS_RSVD = 2'd3;

  localparam logic [2:0] SWZ_FULL = 3'd0;
  localparam logic [2:0] SWZ_X    = 3'd1;
  localparam logic [2:0] SWZ_Y    = 3'd2;
  localparam logic [2:0] SWZ_Z    = 3'd3;
  localparam logic [2:0] SWZ_W    = 3'd4;

  localparam logic [2:0] CMP_GT = 3'd0;
  localparam logic [2:0] CMP_LT = 3'd1;
  localparam logic [2:0] CMP_GE = 3'd2;
  localparam logic [2:0] CMP_LE = 3'd3;
  localparam logic [2:0] CMP_EQ = 3'd4;
  localparam logic [2:0] CMP_NE = 3'd5;
endpackage

// File: rtl/vpred_mask.sv
`timescale 1ns/1ps
module vpred_mask
  import vpred_pkg::*;
(
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic             pen_i,
  input  logic             pinv_i,
  input  logic [2:0]       pswz_i,
  output logic [LANES-1:0] en_o,
  output logic             swz_ok_o
);
  logic [LANES-1:0] sel;
  logic [LANES-1:0] sel_pol;

  always_comb begin
    swz_ok_o = 1'b1;
    case (pswz_i)
      SWZ_FULL: sel = pred_i;
      SWZ_X:    sel = {LANES{pred_i[0]}};
      SWZ_Y:    sel = {LANES{pred_i[1]}};
      SWZ_Z:    sel = {LANES{pred_i[2]}};
      SWZ_W:    sel = {LANES{pred_i[3]}};
      default: begin
        sel      = '0;
        swz_ok_o = 1'b0;
      end
    endcase
    sel_pol = pinv_i ? ~sel : sel;
    en_o    = pen_i ? (wmask_i & sel_pol) : wmask_i;
  end
endmodule

// File: rtl/vpred_cmp.sv
`timescale 1ns/1ps
module vpred_cmp
  import vpred_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [LANES*W-1:0] a_i,
  input  logic [LANES*W-1:0] b_i,
  input  logic [2:0]         op_i,
  input  logic [LANES-1:0]   wmask_i,
  input  logic [LANES-1:0]   pred_cur_i,
  output logic [LANES-1:0]   pred_nxt_o,
  output logic               op_ok_o
);
  logic [LANES-1:0] hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [W-1:0] av;
    logic signed [W-1:0] bv;
    assign av = a_i[g*W +: W];
    assign bv = b_i[g*W +: W];
    always_comb begin
      case (op_i)
        CMP_GT:  hit[g] = av >  bv;
        CMP_LT:  hit[g] = av <  bv;
        CMP_GE:  hit[g] = av >= bv;
        CMP_LE:  hit[g] = av <= bv;
        CMP_EQ:  hit[g] = av == bv;
        CMP_NE:  hit[g] = av != bv;
        default: hit[g] = 1'b0;
      endcase
    end
  end

  assign op_ok_o    = (op_i <= CMP_NE);
  assign pred_nxt_o = (wmask_i & hit) | (~wmask_i & pred_cur_i);
endmodule

// File: rtl/vpred_lane_ram.sv
`timescale 1ns/1ps
module vpred_lane_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/vpred_writeback.sv
`timescale 1ns/1ps
module vpred_writeback
  import vpred_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG),
  localparam int VW  = LANES * W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [1:0]       cls_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic             pen_i,
  input  logic             pinv_i,
  input  logic [2:0]       pswz_i,
  input  logic [2:0]       cmp_i,
  input  logic [VW-1:0]    res_i,
  input  logic [VW-1:0]    opb_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [VW-1:0]    rd_data_o,
  output logic [LANES-1:0] pred_o,
  output logic             err_o
);
  logic [LANES-1:0] pred_q;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_we;
  logic [LANES-1:0] pred_nxt;
  logic             swz_ok;
  logic             op_ok;
  logic             err_now;
  logic             is_alu;
  logic             is_setp;

  vpred_mask u_mask (
    .pred_i   (pred_q),
    .wmask_i  (wmask_i),
    .pen_i    (pen_i),
    .pinv_i   (pinv_i),
    .pswz_i   (pswz_i),
    .en_o     (lane_en),
    .swz_ok_o (swz_ok)
  );

  vpred_cmp #(.W(W)) u_cmp (
    .a_i        (res_i),
    .b_i        (opb_i),
    .op_i       (cmp_i),
    .wmask_i    (wmask_i),
    .pred_cur_i (pred_q),
    .pred_nxt_o (pred_nxt),
    .op_ok_o    (op_ok)
  );

  assign is_alu  = (cls_i == CLS_ALU);
  assign is_setp = (cls_i == CLS_SETP);

  always_comb begin
    err_now = 1'b0;
    if (vld_i) begin
      if (cls_i == CLS_RSVD)      err_now = 1'b1;
      if (pen_i && !is_alu)       err_now = 1'b1;
      if (pen_i && !swz_ok)       err_now = 1'b1;
      if (is_setp && !op_ok)      err_now = 1'b1;
    end
  end

  assign lane_we = (vld_i && is_alu && !err_now) ? lane_en : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_ram
    vpred_lane_ram #(.W(W), .DEPTH(NREG)) u_ram (
      .clk     (clk),
      .rst     (rst),
      .we_i    (lane_we[g]),
      .waddr_i (dst_i),
      .wdata_i (res_i[g*W +: W]),
      .raddr_i (rd_idx_i),
      .rdata_o (rd_data_o[g*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= err_now;
      if (vld_i && is_setp && !err_now) pred_q <= pred_nxt;
    end
  end

  assign pred_o = pred_q;

  // R7
  pred_only_setp_chk: assert property (@(posedge clk) disable iff (rst)
    !(vld_i && is_setp) |=> $stable(pred_o));

  // R5
  flow_pred_err_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && pen_i && cls_i == CLS_FLOW) |=> err_o);

  // R4
  bad_swz_err_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && pen_i && pswz_i > SWZ_W) |=> err_o);

  // R6
  we_only_alu_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |-> (vld_i && is_alu));

  // R1
  false_pred_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && pen_i && !pinv_i && pswz_i == SWZ_FULL && pred_o == '0) |-> (lane_we == '0));

  // R9
  bad_cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && is_setp && cmp_i > CMP_NE) |=> (err_o && $stable(pred_o)));
endmodule

// File: tb/vpred_writeback_tb_top.sv
`timescale 1ns/1ps
module vpred_writeback_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         vld_i;
  logic [1:0]   cls_i;
  logic [3:0]   dst_i;
  logic [3:0]   wmask_i;
  logic         pen_i;
  logic         pinv_i;
  logic [2:0]   pswz_i;
  logic [2:0]   cmp_i;
  logic [127:0] res_i;
  logic [127:0] opb_i;
  logic [3:0]   rd_idx_i;
  logic [127:0] rd_data_o;
  logic [3:0]   pred_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;
  logic [127:0] shadow5;

  always #4 clk = ~clk;

  vpred_writeback dut_i (
    .clk(clk), .rst(rst), .vld_i(vld_i), .cls_i(cls_i), .dst_i(dst_i),
    .wmask_i(wmask_i), .pen_i(pen_i), .pinv_i(pinv_i), .pswz_i(pswz_i),
    .cmp_i(cmp_i), .res_i(res_i), .opb_i(opb_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .pred_o(pred_o), .err_o(err_o)
  );

  function automatic logic [127:0] vec(int l0, int l1, int l2, int l3);
    return {32'(l3), 32'(l2), 32'(l1), 32'(l0)};
  endfunction

  function automatic logic [127:0] merge(logic [127:0] old, logic [127:0] nw, logic [3:0] en);
    logic [127:0] r = old;
    for (int i = 0; i < 4; i++) if (en[i]) r[i*32 +: 32] = nw[i*32 +: 32];
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] cls, logic [3:0] dst, logic [3:0] wm, logic pen,
                       logic inv, logic [2:0] swz, logic [2:0] cmp,
                       logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    vld_i = 1'b1; cls_i = cls; dst_i = dst; wmask_i = wm; pen_i = pen;
    pinv_i = inv; pswz_i = swz; cmp_i = cmp; res_i = a; opb_i = b;
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [127:0] d);
    @(negedge clk);
    rd_idx_i = idx;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic t_reset;
    chk("R11 pred", 128'(pred_o), 128'h0);
    chk("R11 err", 128'(err_o), 128'h0);
    chk("R11 rd_data", rd_data_o, 128'h0);
  endtask

  task automatic t_plain;
    logic [127:0] d;
    logic [127:0] va = vec(11, 22, 33, 44);
    logic [127:0] vb = vec(55, 66, 77, 88);
    logic [127:0] vc = vec(1, 2, 3, 4);
    issue(2'd0, 4'd15, 4'hF, 1'b0, 1'b0, 3'd6, 3'd0, va, '0);
    chk("R4 swizzle ignored when unpredicated", 128'(err_o), 128'h0);
    @(negedge clk);
    rd_idx_i = 4'd15; vld_i = 1'b1; cls_i = 2'd0; dst_i = 4'd15; wmask_i = 4'hF;
    pen_i = 1'b0; res_i = vb;
    @(negedge clk);
    vld_i = 1'b0;
    chk("R10 same-cycle read old", rd_data_o, va);
    @(negedge clk);
    chk("R10 next-cycle read new", rd_data_o, vb);
    issue(2'd0, 4'd15, 4'b0101, 1'b0, 1'b0, 3'd0, 3'd0, vc, '0);
    rd(4'd15, d);
    chk("R6 masked lanes keep", d, vec(1, 66, 3, 88));
  endtask

  task automatic t_setp;
    logic [127:0] a = vec(4, -2, -1, 5);
    logic [127:0] b = vec(3, -2, 9, 5);
    logic [2:0] ops [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    logic [3:0] exp [6] = '{4'b0001, 4'b0100, 4'b1011, 4'b1110, 4'b1010, 4'b0101};
    for (int k = 0; k < 6; k++) begin
      issue(2'd2, 4'd0, 4'hF, 1'b0, 1'b0, 3'd0, ops[k], a, b);
      chk("R8 signed compare", 128'(pred_o), 128'(exp[k]));
    end
    issue(2'd2, 4'd0, 4'b0011, 1'b0, 1'b0, 3'd0, 3'd4, a, b);
    chk("R8 compare honours own mask", 128'(pred_o), 128'(4'b0110));
  endtask

  task automatic pw(logic [3:0] wm, logic inv, logic [2:0] swz, logic [127:0] data,
                    logic [3:0] en, string req);
    logic [127:0] d;
    issue(2'd0, 4'd5, wm, 1'b1, inv, swz, 3'd0, data, '0);
    chk({req, " no error"}, 128'(err_o), 128'h0);
    shadow5 = merge(shadow5, data, en);
    rd(4'd5, d);
    chk(req, d, shadow5);
    chk("R7 predicate untouched by write", 128'(pred_o), 128'(4'b0110));
  endtask

  task automatic t_predwrite;
    logic [127:0] d;
    shadow5 = vec(100, 200, 300, 400);
    issue(2'd0, 4'd5, 4'hF, 1'b0, 1'b0, 3'd0, 3'd0, shadow5, '0);
    rd(4'd5, d);
    chk("R1 unpredicated write", d, shadow5);
    pw(4'hF,   1'b0, 3'd0, vec(1, 2, 3, 4),     4'b0110, "R1 R3 full swizzle");
    pw(4'hF,   1'b1, 3'd0, vec(5, 6, 7, 8),     4'b1001, "R2 inverted full");
    pw(4'b1001,1'b0, 3'd2, vec(9, 10, 11, 12),  4'b1001, "R3 replicate y");
    pw(4'hF,   1'b0, 3'd1, vec(13, 14, 15, 16), 4'b0000, "R3 replicate x false");
    pw(4'b0010,1'b1, 3'd4, vec(17, 18, 19, 20), 4'b0010, "R2 R3 inverted replicate w");
    pw(4'hF,   1'b1, 3'd3, vec(21, 22, 23, 24), 4'b0000, "R2 R3 inverted replicate z");
  endtask

  task automatic t_errors;
    logic [127:0] d;
    issue(2'd0, 4'd5, 4'hF, 1'b1, 1'b0, 3'd5, 3'd0, vec(7, 7, 7, 7), '0);
    chk("R4 illegal swizzle error", 128'(err_o), 128'h1);
    rd(4'd5, d);
    chk("R4 illegal swizzle no write", d, shadow5);
    issue(2'd0, 4'd5, 4'b0001, 1'b0, 1'b0, 3'd7, 3'd0, vec(31, 32, 33, 34), '0);
    chk("R4 swizzle ignored no error", 128'(err_o), 128'h0);
    shadow5 = merge(shadow5, vec(31, 32, 33, 34), 4'b0001);
    rd(4'd5, d);
    chk("R4 unpredicated write with odd swizzle", d, shadow5);
    issue(2'd1, 4'd5, 4'hF, 1'b1, 1'b0, 3'd0, 3'd0, vec(8, 8, 8, 8), '0);
    chk("R5 predicated flow error", 128'(err_o), 128'h1);
    issue(2'd1, 4'd5, 4'hF, 1'b0, 1'b0, 3'd0, 3'd0, vec(9, 9, 9, 9), '0);
    chk("R6 flow plain no error", 128'(err_o), 128'h0);
    rd(4'd5, d);
    chk("R5 R6 flow writes nothing", d, shadow5);
    issue(2'd2, 4'd0, 4'hF, 1'b1, 1'b0, 3'd0, 3'd0, vec(4, -2, -1, 5), vec(3, -2, 9, 5));
    chk("R5 predicated setp error", 128'(err_o), 128'h1);
    chk("R5 predicated setp keeps pred", 128'(pred_o), 128'(4'b0110));
    issue(2'd2, 4'd0, 4'hF, 1'b0, 1'b0, 3'd0, 3'd6, vec(4, -2, -1, 5), vec(3, -2, 9, 5));
    chk("R9 bad compare error", 128'(err_o), 128'h1);
    chk("R9 bad compare keeps pred", 128'(pred_o), 128'(4'b0110));
    issue(2'd3, 4'd5, 4'hF, 1'b0, 1'b0, 3'd0, 3'd0, vec(3, 3, 3, 3), vec(0, 0, 0, 0));
    chk("R5 reserved class error", 128'(err_o), 128'h1);
    rd(4'd5, d);
    chk("R5 reserved class no write", d, shadow5);
    chk("R5 reserved class keeps pred", 128'(pred_o), 128'(4'b0110));
    @(negedge clk);
    chk("R4 error is a single pulse", 128'(err_o), 128'h0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; vld_i = 1'b0; cls_i = '0; dst_i = '0; wmask_i = '0; pen_i = 1'b0;
    pinv_i = 1'b0; pswz_i = '0; cmp_i = '0; res_i = '0; opb_i = '0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_setp();
    t_predwrite();
    t_errors();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule